// File: doc/BRIEF.md
# Single-Port Synchronous RAM with Selectable Write Behaviour

This block is a single-port RAM in which both reads and writes take effect on the rising clock edge, and read data is always delivered from an output register. A parameter chooses what that output register shows during a write cycle: the word just written, the word the address held before the write, or its own previous value. A data field and a parity field are stored side by side as one word.

The output register has two reset paths. A separate synchronous set/reset input loads a parameterised value into it. That input acts only when the port is enabled, and it outranks both a read and the write-cycle behaviour. It does not block the write itself, so the memory is still updated. The block-level active-low reset also loads the same value and suppresses writes. At start-up the memory holds an arithmetic preset pattern, and parameters set its base and step.

A typical use is a lookup or scratch store inside a datapath. There the choice of write behaviour decides whether a read-modify-write sequence can see the old value in the cycle of the write.

Top module: `wmode_sram`

## Requirements
- R1: With `en`=1, `we`=0, `srst`=0 and `rst_n`=1 at a rising edge, `{dout_par,dout}` shows the word stored at `addr` after that edge, and holds it until the next enabled edge.
- R2: With `WRITE_MODE`=`WM_WRITE_FIRST` (encoding 0, the default), an enabled write without `srst` stores `{din_par,din}` at `addr` and presents that same word on the output after the edge.
- R3: With `WRITE_MODE`=`WM_READ_FIRST` (encoding 1), an enabled write without `srst` stores the new word and presents on the output the word that `addr` held before the edge.
- R4: With `WRITE_MODE`=`WM_NO_CHANGE` (encoding 2), an enabled write without `srst` stores the new word and leaves the output register unchanged.
- R5: With `en`=1 and `srst`=1, the output becomes `RESET_VAL` after the edge, whatever the values of `we` and `addr`.
- R6: An enabled write with `srst`=1 still stores `{din_par,din}` at `addr`, as a later read shows.
- R7: With `en`=0, no word is written, and the output keeps its value even if `we` or `srst` is 1.
- R8: Before any write, word i reads as `INIT_BASE + i*INIT_STEP`, truncated to `DATA_W+PAR_W` bits. The parity part is the upper `PAR_W` bits of that word.
- R9: With `rst_n`=0 at an edge, the output becomes `RESET_VAL` and no write takes place, even if `en` and `we` are 1.
- R10: The parity bits `din_par` are stored and returned on `dout_par` together with their data word, and no value is computed from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all actions on its rising edge |
| rst_n | input | 1 | Synchronous active-low block reset |
| en | input | 1 | Port enable; gates reads, writes and `srst` |
| we | input | 1 | Write request |
| srst | input | 1 | Synchronous set/reset of the output register |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| din_par | input | PAR_W | Write parity bits |
| dout | output | DATA_W | Registered read data |
| dout_par | output | PAR_W | Registered read parity bits |

## Verification
The set/reset of the output register and a memory write can fall in the same enabled cycle. The first must win at the output while the second must still land in the array. Random stimulus raises `srst` together with `we` on a small set of addresses, so the two often coincide. Directed cases also pair them on purpose. The bench checks that the output shows `RESET_VAL` after such an edge. It then reads the same address back and checks that the new word was stored. All three write modes are judged in parallel against one reference model.

// File: rtl/wm_pkg.sv
// Package: shared types for the write-mode RAM.
// Assumes: nothing beyond IEEE 1800-2017.
package wm_pkg;

    // What the output register shows in a cycle that writes.
    typedef enum logic [1:0] {
        WM_WRITE_FIRST = 2'd0,
        WM_READ_FIRST  = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wm_mode_e;

endpackage

// File: rtl/wm_storage.sv
// Module: word array with one synchronous write port and a combinational
// look-up of the addressed word. The look-up feeds the output stage, which
// registers it, so no unregistered path reaches the block's pins.
// Assumes: wr_en is already qualified by enable and block reset.
module wm_storage #(
    parameter int ADDR_W = 9,
    parameter int DW     = 36,
    parameter logic [DW-1:0] INIT_BASE = '0,
    parameter logic [DW-1:0] INIT_STEP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DW-1:0] mem [DEPTH];

    // Preset: fill the array with the arithmetic start-up pattern.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = INIT_BASE + DW'(i) * INIT_STEP;
        end
    end

    // Write: store the word on a qualified write edge.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    // Look-up: present the currently addressed word (pre-write value).
    assign rd_word = mem[addr];

    // A qualified write is visible in the array one edge later (R6).
    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(addr)] == $past(wdata));

endmodule

// File: rtl/wm_out_stage.sv
// Module: output register with mode-dependent write behaviour, a
// synchronous set/reset to a programmable value and an enable that freezes it.
// Assumes: rd_word is the addressed word before this edge's write.
module wm_out_stage
    import wm_pkg::*;
#(
    parameter int       DW         = 36,
    parameter wm_mode_e WRITE_MODE = WM_WRITE_FIRST,
    parameter logic [DW-1:0] RESET_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          we,
    input  logic          srst,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rd_word,
    output logic [DW-1:0] q
);
    logic          wr_load;   // whether a write cycle loads q
    logic [DW-1:0] wr_next;   // what a write cycle loads into q

    // Select the write-cycle source by mode.
    generate
        if (WRITE_MODE == WM_WRITE_FIRST) begin : g_wf
            assign wr_load = 1'b1;
            assign wr_next = wdata;
        end else if (WRITE_MODE == WM_READ_FIRST) begin : g_rf
            assign wr_load = 1'b1;
            assign wr_next = rd_word;
        end else begin : g_nc
            assign wr_load = 1'b0;
            assign wr_next = rd_word;
        end
    endgenerate

    // Output register: reset, then enable, set/reset, write, read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (en) begin
            if (srst) begin
                q <= RESET_VAL;
            end else if (we) begin
                if (wr_load) begin
                    q <= wr_next;
                end
            end else begin
                q <= rd_word;
            end
        end
    end

    assert_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !we && !srst) |=> q == $past(rd_word));
    assert_srst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && srst) |=> q == RESET_VAL);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));
    assert_blk_reset_R9: assert property (@(posedge clk)
        !rst_n |=> q == RESET_VAL);

    generate
        if (WRITE_MODE == WM_WRITE_FIRST) begin : g_chk_wf
            assert_wf_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (en && we && !srst) |=> q == $past(wdata));
        end else if (WRITE_MODE == WM_READ_FIRST) begin : g_chk_rf
            assert_rf_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (en && we && !srst) |=> q == $past(rd_word));
        end else begin : g_chk_nc
            assert_nc_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (en && we && !srst) |=> $stable(q));
        end
    endgenerate

endmodule

// File: rtl/wmode_sram.sv
// Module: single-port synchronous RAM with selectable write behaviour.
// Data and parity are kept as one word, parity in the upper bits (R10).
// Assumes: PAR_W >= 1; rst_n is synchronous and active low.
module wmode_sram
    import wm_pkg::*;
#(
    parameter int       ADDR_W     = 9,
    parameter int       DATA_W     = 32,
    parameter int       PAR_W      = 4,
    parameter wm_mode_e WRITE_MODE = WM_WRITE_FIRST,
    parameter logic [DATA_W+PAR_W-1:0] RESET_VAL = '0,
    parameter logic [DATA_W+PAR_W-1:0] INIT_BASE = '0,
    parameter logic [DATA_W+PAR_W-1:0] INIT_STEP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic              srst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic [PAR_W-1:0]  din_par,
    output logic [DATA_W-1:0] dout,
    output logic [PAR_W-1:0]  dout_par
);
    localparam int DW = DATA_W + PAR_W;

    logic          wr_en;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rd_word;
    logic [DW-1:0] q;

    // Qualify writes with the enable and the block reset (R7, R9).
    always_comb begin
        wr_en = en && we && rst_n;
        wdata = {din_par, din};
    end

    wm_storage #(
        .ADDR_W    (ADDR_W),
        .DW        (DW),
        .INIT_BASE (INIT_BASE),
        .INIT_STEP (INIT_STEP)
    ) u_storage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_word (rd_word)
    );

    wm_out_stage #(
        .DW         (DW),
        .WRITE_MODE (WRITE_MODE),
        .RESET_VAL  (RESET_VAL)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .we      (we),
        .srst    (srst),
        .wdata   (wdata),
        .rd_word (rd_word),
        .q       (q)
    );

    assign dout     = q[DATA_W-1:0];
    assign dout_par = q[DW-1:DATA_W];

endmodule

// File: tb/wmode_sram_bench.sv
`timescale 1ns/1ps
module wmode_sram_bench;
    import wm_pkg::*;

    localparam int ADDR_W = 9;
    localparam int DATA_W = 32;
    localparam int PAR_W  = 4;
    localparam int DW     = DATA_W + PAR_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam logic [DW-1:0] RV   = 36'h9DEADBEEF;
    localparam logic [DW-1:0] BASE = 36'h100000003;
    localparam logic [DW-1:0] STEP = 36'h011111111;

    logic clk = 1'b0;
    logic rst_n = 1'b0, en = 1'b0, we = 1'b0, srst = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] din = '0;
    logic [PAR_W-1:0]  din_par = '0;
    logic [DATA_W-1:0] dout [3];
    logic [PAR_W-1:0]  dpar [3];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] expq [3];

    always #2.5 clk = ~clk;

    wmode_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAR_W(PAR_W),
        .WRITE_MODE(WM_WRITE_FIRST), .RESET_VAL(RV), .INIT_BASE(BASE), .INIT_STEP(STEP))
    u_wmode_sram (.clk(clk), .rst_n(rst_n), .en(en), .we(we), .srst(srst), .addr(addr),
        .din(din), .din_par(din_par), .dout(dout[0]), .dout_par(dpar[0]));

    wmode_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAR_W(PAR_W),
        .WRITE_MODE(WM_READ_FIRST), .RESET_VAL(RV), .INIT_BASE(BASE), .INIT_STEP(STEP))
    u_wmode_sram_rf (.clk(clk), .rst_n(rst_n), .en(en), .we(we), .srst(srst), .addr(addr),
        .din(din), .din_par(din_par), .dout(dout[1]), .dout_par(dpar[1]));

    wmode_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAR_W(PAR_W),
        .WRITE_MODE(WM_NO_CHANGE), .RESET_VAL(RV), .INIT_BASE(BASE), .INIT_STEP(STEP))
    u_wmode_sram_nc (.clk(clk), .rst_n(rst_n), .en(en), .we(we), .srst(srst), .addr(addr),
        .din(din), .din_par(din_par), .dout(dout[2]), .dout_par(dpar[2]));

    // Expected output of mode m after an edge, from the requirements.
    function automatic logic [DW-1:0] next_q(int m, logic [DW-1:0] cur, logic [DW-1:0] old,
                                             logic [DW-1:0] wd, logic r, logic e, logic w, logic s);
        if (!r) return RV;                 // R9
        if (!e) return cur;                // R7
        if (s) return RV;                  // R5
        if (w) begin
            if (m == 0) return wd;         // R2
            if (m == 1) return old;        // R3
            return cur;                    // R4
        end
        return old;                        // R1
    endfunction

    function automatic string auto_tag(int m, logic r, logic e, logic w, logic s);
        if (!r) return "R9";
        if (!e) return "R7";
        if (s) return "R5";
        if (w) return (m == 0) ? "R2" : (m == 1) ? "R3" : "R4";
        return "R1";
    endfunction

    // One clock cycle: drive, let the edge pass, update model, check at negedge.
    task automatic step(logic r, logic e, logic w, logic s, logic [ADDR_W-1:0] a,
                        logic [DATA_W-1:0] d, logic [PAR_W-1:0] p, string tag);
        logic [DW-1:0] old;
        rst_n = r; en = e; we = w; srst = s; addr = a; din = d; din_par = p;
        @(posedge clk);
        #1;
        old = model[a];
        for (int m = 0; m < 3; m++) expq[m] = next_q(m, expq[m], old, {p, d}, r, e, w, s);
        if (r && e && w) model[a] = {p, d};
        @(negedge clk);
        for (int m = 0; m < 3; m++) begin
            string t;
            t = (tag == "") ? auto_tag(m, r, e, w, s) : tag;
            checks++;
            if ({dpar[m], dout[m]} !== expq[m]) begin
                errors++;
                $display("FAIL %s mode%0d addr=%0d actual=%h expected=%h", t, m, a,
                         {dpar[m], dout[m]}, expq[m]);
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < DEPTH; i++) model[i] = BASE + DW'(i) * STEP;
        for (int m = 0; m < 3; m++) expq[m] = RV;
        @(negedge clk);
        // R9: reset state, and a write attempted under reset must not land.
        step(0, 0, 0, 0, 0, 0, 0, "R9");
        step(0, 1, 1, 0, 9'd5, 32'hAAAA5555, 4'hA, "R9");
        // R8: sweep preset contents.
        for (int i = 0; i < DEPTH; i++) step(1, 1, 0, 0, ADDR_W'(i), 0, 0, "R8");
        // R2/R3/R4: write to a read-back address, then read it (R1).
        step(1, 1, 0, 0, 9'd7, 0, 0, "R1");
        step(1, 1, 1, 0, 9'd7, 32'h12345678, 4'h6, "");
        step(1, 1, 0, 0, 9'd7, 0, 0, "R1");
        // R10: distinct parity bits travel with the data.
        step(1, 1, 1, 0, 9'd8, 32'h0, 4'hF, "R10");
        step(1, 1, 0, 0, 9'd8, 0, 0, "R10");
        // R5/R6: set/reset together with a write, then read back.
        step(1, 1, 1, 1, 9'd9, 32'hCAFEF00D, 4'h3, "R5");
        step(1, 1, 0, 0, 9'd9, 0, 0, "R6");
        // R7: disabled port ignores write and set/reset.
        step(1, 0, 1, 1, 9'd10, 32'hFFFFFFFF, 4'h1, "R7");
        step(1, 1, 0, 0, 9'd10, 0, 0, "R7");
        // R9: block reset mid-run with a write, then read back unchanged.
        step(0, 1, 1, 0, 9'd11, 32'h0BADBEEF, 4'h2, "R9");
        step(1, 1, 0, 0, 9'd11, 0, 0, "R9");
        // Random mix on few addresses so set/reset and writes collide.
        for (int k = 0; k < 4000; k++) begin
            logic r, e, w, s;
            r = ($urandom % 40) != 0;
            e = ($urandom % 6) != 0;
            w = ($urandom % 2) != 0;
            s = ($urandom % 5) == 0;
            step(r, e, w, s, ADDR_W'($urandom % 16), $urandom, PAR_W'($urandom), "");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule